// File: doc/BRIEF.md
# Memory Request Statistics Gatherer

This block is a performance monitor that sits beside the arbiter of a memory controller. Every cycle the arbiter may present one granted request, and the monitor sees that request's client number, its direction, its three arbitration sideband flags (urgent, deadline-expired, bandwidth-starved), a page-miss flag, an auto-precharge flag and two bank-arbitration flags. Two identical gather units each count the grants that match a chosen event class and pass a client filter and a sideband-flag filter. A shared cycle counter runs beside them, so that a count can later be scaled to the length of the sampling window.

Software programs both gather units and a cycle limit over a simple single-cycle register bus. It then writes a run command, waits for the sampling window, writes a freeze command and reads back the two event counts and the cycle count. Two event classes depend on the previous grant rather than the current one alone: a repeat win by the same client, and a change of direction between consecutive grants.

Top module: `memStatGatherer`

## Requirements
- R1: The registers sit at byte addresses 0x90 (global command), 0xA0 (cycle limit, resets to 0xFFFFFFFF), 0xA4 (cycle count), 0xA8 and 0xAC (control of gather 0 and 1), 0xB8 and 0xBC (count of gather 0 and 1). Read data is valid in the same cycle as `regRdEn`, and counts read zero-extended to 32 bits.
- R2: Global command bits 9:8 select the mode: 3 runs counting from the next cycle on, 2 freezes every counter at its value, 0 and 1 also leave counting stopped.
- R3: Command 0 and command 1 both zero the two event counts and the cycle count. Command 0 also discards the record of the previous grant, while command 1 keeps it.
- R4: While running, the cycle count rises by one per cycle until it equals the cycle limit, then holds.
- R5: A gather control word holds the client number in bits 13:8, the event class in bits 23:16, the sideband flag choice in bits 25:24, the client-filter enable in bit 26 and the flag-filter mode in bits 29:28, and reads back as written.
- R6: Event classes: 0 any grant, 1 read grant, 2 write grant, 5 first bank-arbitration flag set, 6 second bank-arbitration flag set, 7 page-miss flag set, 8 auto-precharge flag set.
- R7: Class 4 counts a grant whose client equals that of the previous grant, so N back-to-back grants to one client count N-1.
- R8: Class 3 counts a grant whose direction (write flag) differs from that of the previous grant.
- R9: With the client filter enabled only grants whose client number equals the programmed one count; with it disabled every client counts.
- R10: Flag choice 0 picks the urgent flag, 1 the deadline flag, 2 the bandwidth flag. Filter mode 1 counts only grants with the chosen flag clear, mode 2 only grants with it set, mode 0 ignores the flag.
- R11: Each event count stops at its all-ones value (width CNT_W) instead of wrapping.
- R12: Event classes above 8 never count, and flag-filter mode 3 behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, zero when no read |
| grantValid | input | 1 | A grant is presented this cycle |
| grantClient | input | 6 | Client number of the grant |
| grantWrite | input | 1 | 1 for a write, 0 for a read |
| grantUrgent | input | 1 | Urgent sideband flag |
| grantDeadline | input | 1 | Deadline-expired sideband flag |
| grantStarved | input | 1 | Bandwidth-starved sideband flag |
| grantPageMiss | input | 1 | Page-miss flag |
| grantAutoPre | input | 1 | Auto-precharge flag |
| grantBankA | input | 1 | First bank-arbitration flag |
| grantBankB | input | 1 | Second bank-arbitration flag |

## Verification
The grant stream is driven with several patterns: mixed clients against a filtered and an unfiltered gather, which separates the client filter from plain counting; alternating directions and repeated clients, which separate the two history classes from one another and from per-grant classes; and grants with crafted flag combinations, which tell the chosen sideband flag and the set/clear filter modes apart. Issuing a grant just after a clear and just after a reset shows whether the previous-grant record survives each. Long idle and long grant runs with a small limit and a narrow counter probe the two saturation points, and grants during freeze show that nothing moves.

// File: rtl/memStatPkg.sv
package memStatPkg;

  localparam int CLIENT_W = 6;
  localparam int REG_W    = 32;

  typedef enum logic [1:0] {
    GM_RESET  = 2'd0,
    GM_CLEAR  = 2'd1,
    GM_FREEZE = 2'd2,
    GM_RUN    = 2'd3
  } gatherModeE;

  // gather control word field positions
  localparam int F_CLIENT_LO = 8;
  localparam int F_EVENT_LO  = 16;
  localparam int F_PSEL_LO   = 24;
  localparam int F_CFILT     = 26;
  localparam int F_PMODE_LO  = 28;
  localparam int F_MODE_LO   = 8;

  // event class codes
  localparam logic [7:0] EV_ANY      = 8'd0;
  localparam logic [7:0] EV_READ     = 8'd1;
  localparam logic [7:0] EV_WRITE    = 8'd2;
  localparam logic [7:0] EV_TURN     = 8'd3;
  localparam logic [7:0] EV_REPEAT   = 8'd4;
  localparam logic [7:0] EV_BANKA    = 8'd5;
  localparam logic [7:0] EV_BANKB    = 8'd6;
  localparam logic [7:0] EV_PAGEMISS = 8'd7;
  localparam logic [7:0] EV_AUTOPRE  = 8'd8;

  typedef struct packed {
    logic zeroCounts;
    logic zeroHistory;
    logic countEn;
  } statStrobeT;

  typedef struct packed {
    logic                valid;
    logic [CLIENT_W-1:0] client;
    logic                write;
    logic                urgent;
    logic                deadline;
    logic                starved;
    logic                pageMiss;
    logic                autoPre;
    logic                bankA;
    logic                bankB;
  } grantT;

  typedef struct packed {
    logic                valid;
    logic [CLIENT_W-1:0] client;
    logic                write;
  } historyT;

endpackage

// File: rtl/statControl.sv
module statControl
  import memStatPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [REG_W-1:0]    clkCountRd,
  input  logic [1:0][REG_W-1:0] evCountRd,
  output statStrobeT          strobe,
  output logic [REG_W-1:0]    clkLimit,
  output logic [1:0][REG_W-1:0] gatherCtrl
);

  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(8'h90);
  localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(8'hA0);
  localparam logic [ADDR_W-1:0] A_CLOCKS = ADDR_W'(8'hA4);
  localparam logic [ADDR_W-1:0] A_CTRL0  = ADDR_W'(8'hA8);
  localparam logic [ADDR_W-1:0] A_CTRL1  = ADDR_W'(8'hAC);
  localparam logic [ADDR_W-1:0] A_COUNT0 = ADDR_W'(8'hB8);
  localparam logic [ADDR_W-1:0] A_COUNT1 = ADDR_W'(8'hBC);

  gatherModeE modeQ;
  gatherModeE modeWr;
  logic       wrGlobal;

  assign wrGlobal = regWrEn && (regAddr == A_GLOBAL);
  assign modeWr   = gatherModeE'(regWrData[F_MODE_LO +: 2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= GM_RESET;
      clkLimit   <= '1;
      gatherCtrl <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        A_GLOBAL: modeQ         <= modeWr;
        A_LIMIT:  clkLimit      <= regWrData;
        A_CTRL0:  gatherCtrl[0] <= regWrData;
        A_CTRL1:  gatherCtrl[1] <= regWrData;
        default:  ;
      endcase
    end
  end

  always_comb begin
    strobe.countEn     = (modeQ == GM_RUN);
    strobe.zeroCounts  = wrGlobal && ((modeWr == GM_RESET) || (modeWr == GM_CLEAR));
    strobe.zeroHistory = wrGlobal && (modeWr == GM_RESET);
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        A_GLOBAL: regRdData = REG_W'({modeQ, 8'h00});
        A_LIMIT:  regRdData = clkLimit;
        A_CLOCKS: regRdData = clkCountRd;
        A_CTRL0:  regRdData = gatherCtrl[0];
        A_CTRL1:  regRdData = gatherCtrl[1];
        A_COUNT0: regRdData = evCountRd[0];
        A_COUNT1: regRdData = evCountRd[1];
        default:  regRdData = '0;
      endcase
    end
  end

  // R2
  run_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrGlobal && modeWr == GM_RUN) |=> strobe.countEn);

  // R2
  stop_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrGlobal && modeWr != GM_RUN) |=> !strobe.countEn);

endmodule

// File: rtl/statGatherUnit.sv
module statGatherUnit
  import memStatPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  statStrobeT       strobe,
  input  grantT            grant,
  input  historyT          prev,
  input  logic [REG_W-1:0] ctrlWord,
  output logic [CNT_W-1:0] evCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CLIENT_W-1:0] selClient;
  logic [7:0]          selEvent;
  logic [1:0]          selPrio;
  logic                clientFiltOn;
  logic [1:0]          prioMode;
  logic                unusedCtrl;

  assign selClient    = ctrlWord[F_CLIENT_LO +: CLIENT_W];
  assign selEvent     = ctrlWord[F_EVENT_LO +: 8];
  assign selPrio      = ctrlWord[F_PSEL_LO +: 2];
  assign clientFiltOn = ctrlWord[F_CFILT];
  assign prioMode     = ctrlWord[F_PMODE_LO +: 2];
  assign unusedCtrl   = ^{ctrlWord[7:0], ctrlWord[15:14], ctrlWord[27], ctrlWord[31:30]};

  logic eventHit, prioFlag, prioPass, clientPass, countHit;

  always_comb begin
    unique case (selEvent)
      EV_ANY:      eventHit = 1'b1;
      EV_READ:     eventHit = !grant.write;
      EV_WRITE:    eventHit = grant.write;
      EV_TURN:     eventHit = prev.valid && (grant.write != prev.write);
      EV_REPEAT:   eventHit = prev.valid && (grant.client == prev.client);
      EV_BANKA:    eventHit = grant.bankA;
      EV_BANKB:    eventHit = grant.bankB;
      EV_PAGEMISS: eventHit = grant.pageMiss;
      EV_AUTOPRE:  eventHit = grant.autoPre;
      default:     eventHit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (selPrio)
      2'd0:    prioFlag = grant.urgent;
      2'd1:    prioFlag = grant.deadline;
      2'd2:    prioFlag = grant.starved;
      default: prioFlag = 1'b0;
    endcase
    unique case (prioMode)
      2'd1:    prioPass = !prioFlag;
      2'd2:    prioPass = prioFlag;
      default: prioPass = 1'b1;
    endcase
  end

  assign clientPass = !clientFiltOn || (grant.client == selClient);
  assign countHit   = strobe.countEn && grant.valid && eventHit && prioPass && clientPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evCount <= '0;
    end else if (strobe.zeroCounts) begin
      evCount <= '0;
    end else if (countHit && (evCount != CNT_MAX)) begin
      evCount <= evCount + 1'b1;
    end
  end

  // R11
  ev_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evCount == CNT_MAX && !strobe.zeroCounts) |=> (evCount == CNT_MAX));

  // R3
  ev_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroCounts |=> (evCount == '0));

  // R2
  ev_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.zeroCounts) |=> $stable(evCount));

  // R6
  ev_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.zeroCounts) |=> (evCount == $past(evCount) || evCount == $past(evCount) + 1'b1));

  // R12
  ev_badcode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selEvent > EV_AUTOPRE && !strobe.zeroCounts) |=> $stable(evCount));

endmodule

// File: rtl/statDatapath.sv
module statDatapath
  import memStatPkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int GATHERS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  statStrobeT                  strobe,
  input  grantT                       grant,
  input  logic [REG_W-1:0]            clkLimit,
  input  logic [GATHERS-1:0][REG_W-1:0] gatherCtrl,
  output logic [REG_W-1:0]            clkCountRd,
  output logic [GATHERS-1:0][REG_W-1:0] evCountRd
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  historyT         prev;
  logic [CNT_W-1:0] clkCount;
  logic            clkAtLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prev <= '0;
    end else if (strobe.zeroHistory) begin
      prev <= '0;
    end else if (strobe.countEn && grant.valid) begin
      prev.valid  <= 1'b1;
      prev.client <= grant.client;
      prev.write  <= grant.write;
    end
  end

  assign clkAtLimit = (REG_W'(clkCount) >= clkLimit) || (clkCount == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCount <= '0;
    end else if (strobe.zeroCounts) begin
      clkCount <= '0;
    end else if (strobe.countEn && !clkAtLimit) begin
      clkCount <= clkCount + 1'b1;
    end
  end

  assign clkCountRd = REG_W'(clkCount);

  for (genvar g = 0; g < GATHERS; g++) begin : gGather
    logic [CNT_W-1:0] count;
    statGatherUnit #(.CNT_W(CNT_W)) uGather (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .grant    (grant),
      .prev     (prev),
      .ctrlWord (gatherCtrl[g]),
      .evCount  (count)
    );
    assign evCountRd[g] = REG_W'(count);
  end

  // R4
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (REG_W'(clkCount) >= clkLimit && !strobe.zeroCounts) |=> $stable(clkCount));

  // R4
  clk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.zeroCounts && REG_W'(clkCount) < clkLimit && clkCount != CNT_MAX)
      |=> (clkCount == $past(clkCount) + 1'b1));

  // R3
  clk_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroCounts |=> (clkCount == '0));

  // R3
  hist_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroHistory |=> !prev.valid);

endmodule

// File: rtl/memStatGatherer.sv
module memStatGatherer
  import memStatPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              grantValid,
  input  logic [5:0]        grantClient,
  input  logic              grantWrite,
  input  logic              grantUrgent,
  input  logic              grantDeadline,
  input  logic              grantStarved,
  input  logic              grantPageMiss,
  input  logic              grantAutoPre,
  input  logic              grantBankA,
  input  logic              grantBankB
);

  statStrobeT             strobe;
  grantT                  grant;
  logic [REG_W-1:0]       clkLimit;
  logic [REG_W-1:0]       clkCountRd;
  logic [1:0][REG_W-1:0]  gatherCtrl;
  logic [1:0][REG_W-1:0]  evCountRd;

  always_comb begin
    grant.valid    = grantValid;
    grant.client   = grantClient;
    grant.write    = grantWrite;
    grant.urgent   = grantUrgent;
    grant.deadline = grantDeadline;
    grant.starved  = grantStarved;
    grant.pageMiss = grantPageMiss;
    grant.autoPre  = grantAutoPre;
    grant.bankA    = grantBankA;
    grant.bankB    = grantBankB;
  end

  statControl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .clkCountRd (clkCountRd),
    .evCountRd  (evCountRd),
    .strobe     (strobe),
    .clkLimit   (clkLimit),
    .gatherCtrl (gatherCtrl)
  );

  statDatapath #(.CNT_W(CNT_W), .GATHERS(2)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .grant      (grant),
    .clkLimit   (clkLimit),
    .gatherCtrl (gatherCtrl),
    .clkCountRd (clkCountRd),
    .evCountRd  (evCountRd)
  );

endmodule

// File: tb/memStatGatherer_test.sv
`timescale 1ns/1ps
module memStatGatherer_test;

  localparam int TB_CNT_W = 8;
  localparam logic [7:0] A_GLOBAL = 8'h90, A_LIMIT = 8'hA0, A_CLOCKS = 8'hA4,
                         A_CTRL0 = 8'hA8, A_CTRL1 = 8'hAC, A_COUNT0 = 8'hB8, A_COUNT1 = 8'hBC;
  localparam logic [31:0] CMD_RESET = 32'h000, CMD_CLEAR = 32'h100,
                          CMD_FREEZE = 32'h200, CMD_RUN = 32'h300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn, regRdEn;
  logic [7:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic grantValid, grantWrite, grantUrgent, grantDeadline, grantStarved;
  logic grantPageMiss, grantAutoPre, grantBankA, grantBankB;
  logic [5:0] grantClient;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItemT;
  expItemT expQ[$];

  always #2.5 clk = ~clk;

  memStatGatherer #(.CNT_W(TB_CNT_W), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .grantValid(grantValid), .grantClient(grantClient), .grantWrite(grantWrite),
    .grantUrgent(grantUrgent), .grantDeadline(grantDeadline), .grantStarved(grantStarved),
    .grantPageMiss(grantPageMiss), .grantAutoPre(grantAutoPre),
    .grantBankA(grantBankA), .grantBankB(grantBankB)
  );

  task automatic setIdle();
    regWrEn = 0; regRdEn = 0; regAddr = '0; regWrData = '0;
    grantValid = 0; grantClient = '0; grantWrite = 0; grantUrgent = 0;
    grantDeadline = 0; grantStarved = 0; grantPageMiss = 0; grantAutoPre = 0;
    grantBankA = 0; grantBankB = 0;
  endtask

  task automatic idleCycle();
    @(posedge clk); #1; setIdle();
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1; setIdle();
    regWrEn = 1; regAddr = a; regWrData = d;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rdReg(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItemT it;
    @(posedge clk); #1; setIdle();
    regRdEn = 1; regAddr = a;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic issue(input logic [5:0] c, input logic w, input logic urg, input logic dl,
                       input logic st, input logic pm, input logic ap,
                       input logic ba, input logic bb);
    @(posedge clk); #1; setIdle();
    grantValid = 1; grantClient = c; grantWrite = w; grantUrgent = urg;
    grantDeadline = dl; grantStarved = st; grantPageMiss = pm; grantAutoPre = ap;
    grantBankA = ba; grantBankB = bb;
  endtask

  task automatic simple(input logic [5:0] c, input logic w);
    issue(c, w, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (regRdEn) begin
      expItemT it;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h", regRdData);
      end else begin
        it = expQ.pop_front();
        if (regRdData !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, regRdData, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    setIdle();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rdReg(A_LIMIT,  32'hFFFF_FFFF, "R1 limit reset");
    rdReg(A_CLOCKS, 32'h0, "R1 clocks reset");
    rdReg(A_COUNT0, 32'h0, "R1 count0 reset");
    rdReg(A_COUNT1, 32'h0, "R1 count1 reset");

    // R5 / R9: gather1 filters client 5
    wrReg(A_CTRL0, 32'h0);
    wrReg(A_CTRL1, (32'd1 << 26) | (32'd5 << 8));
    rdReg(A_CTRL1, 32'h0400_0500, "R5 ctrl1 readback");
    wrReg(A_GLOBAL, CMD_RUN);
    simple(5, 0); simple(5, 1); simple(3, 0); simple(5, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd4, "R9 unfiltered count");
    rdReg(A_COUNT1, 32'd3, "R9 filtered count");
    rdReg(A_CLOCKS, 32'd5, "R4 cycles while running");
    simple(5, 0); simple(5, 0);
    rdReg(A_COUNT0, 32'd4, "R2 frozen count0");
    rdReg(A_CLOCKS, 32'd5, "R2 frozen clocks");

    // R3 clear
    wrReg(A_GLOBAL, CMD_CLEAR);
    rdReg(A_COUNT0, 32'd0, "R3 clear count0");
    rdReg(A_CLOCKS, 32'd0, "R3 clear clocks");
    simple(5, 0);
    rdReg(A_COUNT1, 32'd0, "R2 clear leaves counting stopped");

    // R6 read / write classes
    wrReg(A_CTRL0, 32'd1 << 16);
    wrReg(A_CTRL1, 32'd2 << 16);
    wrReg(A_GLOBAL, CMD_RUN);
    simple(0, 0); simple(1, 1); simple(0, 1); simple(2, 0); simple(0, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd3, "R6 read class");
    rdReg(A_COUNT1, 32'd2, "R6 write class");

    // R7 / R8 history classes (previous grant: client 0 read)
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_CTRL0, 32'd4 << 16);
    wrReg(A_CTRL1, 32'd3 << 16);
    wrReg(A_GLOBAL, CMD_RUN);
    simple(2, 0); simple(2, 0); simple(2, 1); simple(4, 1); simple(4, 1); simple(2, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd3, "R7 repeat wins");
    rdReg(A_COUNT1, 32'd2, "R8 direction changes");

    // R3 clear keeps history, reset drops it (previous: client 2 read)
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    simple(2, 1);
    rdReg(A_COUNT0, 32'd1, "R3 history kept by clear (repeat)");
    rdReg(A_COUNT1, 32'd1, "R3 history kept by clear (turn)");
    wrReg(A_GLOBAL, CMD_RESET);
    wrReg(A_GLOBAL, CMD_RUN);
    simple(2, 0);
    rdReg(A_COUNT0, 32'd0, "R3 history dropped by reset (repeat)");
    rdReg(A_COUNT1, 32'd0, "R3 history dropped by reset (turn)");
    wrReg(A_GLOBAL, CMD_FREEZE);

    // R10 flag filters: g0 deadline must be set, g1 urgent must be clear
    wrReg(A_CTRL0, (32'd1 << 24) | (32'd2 << 28));
    wrReg(A_CTRL1, (32'd0 << 24) | (32'd1 << 28));
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    issue(1, 0, 1, 0, 1, 0, 0, 0, 0);
    issue(1, 0, 0, 1, 0, 0, 0, 0, 0);
    issue(1, 0, 1, 1, 0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 1, 0, 0, 0, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd2, "R10 deadline set");
    rdReg(A_COUNT1, 32'd2, "R10 urgent clear");

    // R10 bandwidth flag set
    wrReg(A_CTRL0, (32'd2 << 24) | (32'd2 << 28));
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    issue(1, 0, 1, 1, 0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 1, 0, 0, 0, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd1, "R10 bandwidth set");

    // R6 page miss / auto-precharge
    wrReg(A_CTRL0, 32'd7 << 16);
    wrReg(A_CTRL1, 32'd8 << 16);
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    issue(3, 0, 0, 0, 0, 1, 0, 0, 0);
    issue(3, 0, 0, 0, 0, 1, 1, 0, 0);
    issue(3, 0, 0, 0, 0, 0, 0, 0, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd2, "R6 page miss");
    rdReg(A_COUNT1, 32'd1, "R6 auto-precharge");

    // R6 bank arbitration flags
    wrReg(A_CTRL0, 32'd5 << 16);
    wrReg(A_CTRL1, 32'd6 << 16);
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    issue(3, 0, 0, 0, 0, 0, 0, 1, 0);
    issue(3, 0, 0, 0, 0, 0, 0, 1, 1);
    issue(3, 0, 0, 0, 0, 0, 0, 0, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd2, "R6 bank A");
    rdReg(A_COUNT1, 32'd1, "R6 bank B");

    // R12 unknown class, filter mode 3
    wrReg(A_CTRL0, 32'd9 << 16);
    wrReg(A_CTRL1, 32'd3 << 28);
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    issue(1, 0, 1, 0, 0, 0, 0, 0, 0);
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0);
    issue(1, 0, 1, 1, 1, 0, 0, 0, 0);
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd0, "R12 class 9 never counts");
    rdReg(A_COUNT1, 32'd3, "R12 filter mode 3 passes all");

    // R4 cycle limit
    wrReg(A_LIMIT, 32'd10);
    rdReg(A_LIMIT, 32'd10, "R1 limit readback");
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    repeat (15) idleCycle();
    rdReg(A_CLOCKS, 32'd10, "R4 cycle count held at limit");
    wrReg(A_GLOBAL, CMD_FREEZE);
    wrReg(A_LIMIT, 32'hFFFF_FFFF);

    // R11 count saturation (narrow counter)
    wrReg(A_CTRL0, 32'h0);
    wrReg(A_GLOBAL, CMD_CLEAR);
    wrReg(A_GLOBAL, CMD_RUN);
    for (int i = 0; i < 300; i++) simple(6'(i % 7), 1'(i % 2));
    wrReg(A_GLOBAL, CMD_FREEZE);
    rdReg(A_COUNT0, 32'd255, "R11 count0 saturates");
    rdReg(A_COUNT1, 32'd255, "R11 count1 saturates");
    rdReg(A_CLOCKS, 32'd255, "R11 cycle count saturates at width");

    idleCycle();
    idleCycle();
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule